// File: doc/BRIEF.md
# EDO DRAM Sequencing Controller

This block connects a synchronous host request stream to an asynchronous extended-data-out DRAM. One host word address of 17 bits is split into an 8-bit row and a 9-bit column. The block drives both halves, one after the other, onto one set of multiplexed address pins. It generates the active-low row strobe, column strobe, write enable and output enable. Every minimum pulse width and delay is a parameter counted in clock cycles. When a request targets the row that is already open, the controller keeps the row strobe low and issues only a new column strobe, which gives a page burst. Read data is captured while the column strobe is already high again. This works because the device keeps its output valid until the next column strobe falls, so page cycles stay short.

A refresh timer asks for one refresh per interval, nominally the 8 ms retention window divided by 512 rows, in clock ticks. Refresh uses the column-before-row sequence. The device supplies the row from its own counter, so the address pins are don't-care and no data moves. A pending refresh is served before any new host request, and it closes an open page first.

Host interface rules. A request moves on a clock edge where `req_valid` and `req_ready` are both high. The host must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` stable until that edge. `req_ready` is high in two cases, and never while a refresh is pending:
- The controller is idle with the row strobe high and precharge done.
- A page is open, the presented address hits that row, and the burst is not full.

If a request misses the open row, `req_ready` stays low until the page has been closed and precharged. Read data returns in request order as a one-cycle `rd_valid` pulse. The read-data side has no back-pressure, so the host must accept data on every pulse.

Top module: `edo_dram_ctrl`

## Requirements
- R1: A host address splits as row = `req_addr[16:9]` and column = `req_addr[8:0]`. The row appears on `dram_addr[7:0]`, with `dram_addr[8]` at 0, in the cycle the row strobe falls. The column appears on `dram_addr[8:0]` in the cycle the column strobe falls, and stays there while the column strobe is low.
- R2: For a read, `dram_we_n` stays 1 and `dram_oe_n` is 0 while the column strobe is low. `rd_data` carries the value on `dram_dq_in` during the first cycle after the column strobe rises. `rd_valid` is 1 for exactly the next cycle, and reads return in request order.
- R3: Writes are early writes. `dram_we_n` falls and `dram_dq_oe` goes 1, with the write data on `dram_dq_out`, at least one cycle before the column strobe falls. Neither changes while the column strobe is low. `dram_oe_n` is 1 whenever `dram_dq_oe` is 1.
- R4: A request accepted while a row is open and matching issues only a new column strobe: the row strobe does not rise between the two accesses. A request for a different row is not accepted until the open page has been closed.
- R5: The controller requests one refresh every `REF_TICKS` clock cycles. Its default is `REF_WINDOW_US*CLK_MHZ/REF_ROWS`.
- R6: A refresh drives the column strobe low for at least `T_CSR` cycles before the row strobe falls, with the row strobe high at that point. During the refresh `dram_oe_n` is 1, `dram_dq_oe` is 0 and `req_ready` is 0.
- R7: A pending refresh has priority over host requests. It closes an open page even when the host is idle.
- R8: The row strobe stays low for at least `T_RAS` cycles.
- R9: The row strobe stays high for at least `T_RP` cycles before it falls again.
- R10: The column strobe falls no earlier than `T_RCD` cycles after the row strobe fell. It stays low for at least `T_CAS` cycles and high for at least `T_CP` cycles between data accesses.
- R11: At most `MAX_BURST` column accesses happen in one row-strobe-low period. A burst that reaches this count closes the page, and later requests to the same row open it again.
- R12: While `rst_n` is 0, all four strobes are 1, `dram_dq_oe` is 0 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address, row in [16:9], column in [8:0] |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Write data toward the device |
| dram_dq_oe | output | 1 | 1 = controller drives the data bus |
| dram_dq_in | input | 16 | Data from the device |

## Verification
The bench targets several corner cases, each with the symptom a faulty design would show:
- **Page bursts that fill to the burst limit.** A counter off by one shows up either as a ninth access under one row strobe or as an early close and an extra row opening.
- **Row misses right after a page hit.** A wrong row compare corrupts data, because the column would land in the stale row.
- **Refreshes that arrive while a page sits open with no host traffic.** If refresh did not close the page, refresh gaps would grow far beyond the timer interval.
- **Reads of addresses 0 and the top of the address space.** These catch a mis-split address.
- **Write data and strobe widths.** A late write enable or a short strobe would break the minimum widths that the device model measures on every cycle.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [3:0] {
    S_IDLE,   // row strobe high, precharged
    S_ROW,    // row strobe low, waiting before column phase
    S_SETUP,  // column address and write enable set up
    S_CASLO,  // column strobe low
    S_CASHI,  // column strobe high, EDO data captured
    S_PAGE,   // row open, waiting for next request
    S_CLOSE,  // waiting for minimum row-low time
    S_PRE,    // row precharge
    S_RCSR,   // refresh: column strobe low, row strobe high
    S_RRAS    // refresh: both strobes low
  } seq_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int TICKS = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt;
  logic          expire;

  assign expire = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= CW'(TICKS - 1);
      pend_o <= 1'b0;
    end else begin
      cnt    <= expire ? CW'(TICKS - 1) : cnt - 1'b1;
      pend_o <= expire | (pend_o & ~ack_i);
    end
  end
endmodule

// File: rtl/edo_page_tracker.sv
module edo_page_tracker #(
  parameter int ROW_W     = 8,
  parameter int MAX_BURST = 256,
  parameter int T_RAS     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             close_i,
  input  logic             col_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             hit_o,
  output logic             full_o,
  output logic             ras_ok_o
);
  localparam int BW = $clog2(MAX_BURST + 1);
  localparam int RW = $clog2(T_RAS + 1);

  logic [ROW_W-1:0] open_row;
  logic             row_valid;
  logic [BW-1:0]    burst_cnt;
  logic [RW-1:0]    ras_cnt;

  assign hit_o    = row_valid && (cmp_row_i == open_row);
  assign full_o   = (burst_cnt >= BW'(MAX_BURST));
  assign ras_ok_o = (ras_cnt >= RW'(T_RAS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row  <= '0;
      row_valid <= 1'b0;
      burst_cnt <= '0;
      ras_cnt   <= '0;
    end else begin
      if (open_i) begin
        open_row  <= row_i;
        row_valid <= 1'b1;
        burst_cnt <= '0;
        ras_cnt   <= RW'(1);
      end else begin
        if (close_i) row_valid <= 1'b0;
        if (col_i && !full_o) burst_cnt <= burst_cnt + 1'b1;
        if (row_valid && !ras_ok_o) ras_cnt <= ras_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edo_sequencer.sv
module edo_sequencer
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 9,
  parameter int DW    = 16,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_CP  = 1,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_CSR = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic                             req_write,
  input  logic [ROW_W-1:0]                 req_row,
  input  logic [COL_W-1:0]                 req_col,
  input  logic [DW-1:0]                    req_wdata,
  output logic                             req_ready,
  input  logic                             ref_pend,
  output logic                             ref_ack,
  input  logic                             hit,
  input  logic                             full,
  input  logic                             ras_ok,
  output logic                             trk_open,
  output logic                             trk_close,
  output logic                             trk_col,
  output logic [max_of(ROW_W,COL_W)-1:0]   pin_addr,
  output logic                             ras_n,
  output logic                             cas_n,
  output logic                             we_n,
  output logic                             oe_n,
  output logic [DW-1:0]                    dq_out,
  output logic                             dq_oe,
  input  logic [DW-1:0]                    dq_in,
  output logic [DW-1:0]                    rd_data,
  output logic                             rd_valid
);
  localparam int PA_W = max_of(ROW_W, COL_W);
  localparam int TMAX = max_of(max_of(max_of(T_RCD, T_CAS), max_of(T_CP, T_RAS)),
                               max_of(T_RP, T_CSR));
  localparam int CW   = $clog2(TMAX + 1);

  seq_state_t       state;
  logic [CW-1:0]    cnt;
  logic             wr_q;
  logic [COL_W-1:0] col_q;
  logic             cap;
  logic             cnt_done;

  assign cnt_done  = (cnt == '0);
  assign req_ready = !ref_pend &&
                     ((state == S_IDLE) || ((state == S_PAGE) && hit && !full));
  assign ref_ack   = (state == S_IDLE) && ref_pend;
  assign trk_open  = (state == S_IDLE) && !ref_pend && req_valid;
  assign trk_close = (state == S_CLOSE) && ras_ok;
  assign trk_col   = (state == S_SETUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      pin_addr <= '0;
      wr_q     <= 1'b0;
      col_q    <= '0;
      cap      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      cap      <= 1'b0;
      if (cap) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
      end
      unique case (state)
        S_IDLE: begin
          if (ref_pend) begin
            cas_n <= 1'b0;
            cnt   <= CW'(T_CSR - 1);
            state <= S_RCSR;
          end else if (req_valid) begin
            ras_n    <= 1'b0;
            pin_addr <= PA_W'(req_row);
            wr_q     <= req_write;
            col_q    <= req_col;
            dq_out   <= req_wdata;
            cnt      <= CW'(T_RCD - 2);
            state    <= S_ROW;
          end
        end
        S_ROW: begin
          if (cnt_done) begin
            pin_addr <= PA_W'(col_q);
            we_n     <= ~wr_q;
            oe_n     <= wr_q;
            dq_oe    <= wr_q;
            state    <= S_SETUP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_SETUP: begin
          cas_n <= 1'b0;
          cnt   <= CW'(T_CAS - 1);
          state <= S_CASLO;
        end
        S_CASLO: begin
          if (cnt_done) begin
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            cap   <= ~wr_q;
            cnt   <= CW'(T_CP - 1);
            state <= S_CASHI;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CASHI: begin
          if (cnt_done) state <= S_PAGE;
          else          cnt   <= cnt - 1'b1;
        end
        S_PAGE: begin
          if (ref_pend || full) begin
            state <= S_CLOSE;
          end else if (req_valid) begin
            if (hit) begin
              pin_addr <= PA_W'(req_col);
              wr_q     <= req_write;
              we_n     <= ~req_write;
              oe_n     <= req_write;
              dq_oe    <= req_write;
              dq_out   <= req_wdata;
              state    <= S_SETUP;
            end else begin
              state <= S_CLOSE;
            end
          end
        end
        S_CLOSE: begin
          if (ras_ok) begin
            ras_n <= 1'b1;
            oe_n  <= 1'b1;
            cnt   <= CW'(T_RP - 1);
            state <= S_PRE;
          end
        end
        S_PRE: begin
          if (cnt_done) state <= S_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        S_RCSR: begin
          if (cnt_done) begin
            ras_n <= 1'b0;
            cnt   <= CW'(T_RAS - 1);
            state <= S_RRAS;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RRAS: begin
          if (cnt_done) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            cnt   <= CW'(T_RP - 1);
            state <= S_PRE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int DW            = 16,
  parameter int ROW_W         = 8,
  parameter int COL_W         = 9,
  parameter int T_RCD         = 2,
  parameter int T_CAS         = 2,
  parameter int T_CP          = 1,
  parameter int T_RAS         = 6,
  parameter int T_RP          = 3,
  parameter int T_CSR         = 1,
  parameter int CLK_MHZ       = 100,
  parameter int REF_WINDOW_US = 8000,
  parameter int REF_ROWS      = 512,
  parameter int REF_TICKS     = REF_WINDOW_US * CLK_MHZ / REF_ROWS,
  parameter int MAX_BURST     = 256
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_write,
  input  logic [ROW_W+COL_W-1:0]                 req_addr,
  input  logic [DW-1:0]                          req_wdata,
  output logic                                   rd_valid,
  output logic [DW-1:0]                          rd_data,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic                                   dram_ras_n,
  output logic                                   dram_cas_n,
  output logic                                   dram_we_n,
  output logic                                   dram_oe_n,
  output logic [DW-1:0]                          dram_dq_out,
  output logic                                   dram_dq_oe,
  input  logic [DW-1:0]                          dram_dq_in
);
  localparam int AW = ROW_W + COL_W;

  logic             ref_pend;
  logic             ref_ack;
  logic             hit;
  logic             full;
  logic             ras_ok;
  logic             trk_open;
  logic             trk_close;
  logic             trk_col;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;

  assign req_row = req_addr[AW-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  edo_refresh_timer #(.TICKS(REF_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack_i  (ref_ack),
    .pend_o (ref_pend)
  );

  edo_page_tracker #(
    .ROW_W(ROW_W), .MAX_BURST(MAX_BURST), .T_RAS(T_RAS)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_i    (trk_open),
    .row_i     (req_row),
    .close_i   (trk_close),
    .col_i     (trk_col),
    .cmp_row_i (req_row),
    .hit_o     (hit),
    .full_o    (full),
    .ras_ok_o  (ras_ok)
  );

  edo_sequencer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_row   (req_row),
    .req_col   (req_col),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .hit       (hit),
    .full      (full),
    .ras_ok    (ras_ok),
    .trk_open  (trk_open),
    .trk_close (trk_close),
    .trk_col   (trk_col),
    .pin_addr  (dram_addr),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .dq_out    (dram_dq_out),
    .dq_oe     (dram_dq_oe),
    .dq_in     (dram_dq_in),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );
endmodule

// File: rtl/edo_ctrl_checker.sv
module edo_ctrl_checker #(
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_CAS     = 2,
  parameter int MAX_BURST = 256
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe
);
  logic [15:0] ras_lo_cnt, ras_hi_cnt, cas_lo_cnt, col_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_cnt <= '0;
      ras_hi_cnt <= 16'(T_RP);
      cas_lo_cnt <= '0;
      col_cnt    <= '0;
    end else begin
      ras_lo_cnt <= ras_n ? '0 : ((ras_lo_cnt == 16'hFFFF) ? ras_lo_cnt : ras_lo_cnt + 1'b1);
      ras_hi_cnt <= !ras_n ? '0 : ((ras_hi_cnt == 16'hFFFF) ? ras_hi_cnt : ras_hi_cnt + 1'b1);
      cas_lo_cnt <= cas_n ? '0 : ((cas_lo_cnt == 16'hFFFF) ? cas_lo_cnt : cas_lo_cnt + 1'b1);
      if (ras_n)                           col_cnt <= '0;
      else if ($fell(cas_n) && col_cnt != 16'hFFFF) col_cnt <= col_cnt + 1'b1;
    end
  end

  // R12: strobes idle under reset
  a_r12_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid));

  // R3: controller never drives while device output is enabled
  a_r3_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  // R3: write enable leads the column strobe
  a_r3_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> $past(!we_n));

  // R3: write enable steady while column strobe low
  a_r3_we_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(we_n));

  // R6: refresh keeps bus quiet and host blocked
  a_r6_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> (oe_n && !dq_oe && !req_ready));

  // R8: minimum row-low time
  a_r8_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_lo_cnt >= 16'(T_RAS)));

  // R9: minimum precharge
  a_r9_rp_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ras_hi_cnt >= 16'(T_RP)));

  // R10: minimum column-low width
  a_r10_cas_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (cas_lo_cnt >= 16'(T_CAS)));

  // R11: burst limit per row-low period
  a_r11_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> (col_cnt < 16'(MAX_BURST)));

  // R4: a page-hit accept keeps the row open
  a_r4_page_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ras_n) |=> !ras_n);
endmodule

bind edo_dram_ctrl edo_ctrl_checker #(
  .T_RAS(T_RAS), .T_RP(T_RP), .T_CAS(T_CAS), .MAX_BURST(MAX_BURST)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .ras_n     (dram_ras_n),
  .cas_n     (dram_cas_n),
  .we_n      (dram_we_n),
  .oe_n      (dram_oe_n),
  .dq_oe     (dram_dq_oe)
);

// File: tb/edo_dram_ctrl_bench.sv
module edo_dram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RAS = 6, T_RP = 3, T_CSR = 1;
  localparam int REF_TICKS = 400;
  localparam int MAX_BURST = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [8:0]  dram_addr;
  logic        ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [15:0] dq_out;
  logic [15:0] dq_in = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_dram_ctrl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_CSR(T_CSR), .REF_TICKS(REF_TICKS), .MAX_BURST(MAX_BURST)
  ) u_edo_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] fill(input logic [16:0] a);
    return 16'(a * 13) ^ 16'h5A5A;
  endfunction

  typedef struct { bit w; logic [16:0] a; logic [15:0] d; } op_t;
  op_t         exp_ops[$];
  logic [15:0] exp_rd[$];
  logic [15:0] ref_mem [int];
  logic [15:0] dev_mem [int];

  // device model state
  bit   p_ras = 1, p_cas = 1;
  int   ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_hi = 100, we_lo = 0;
  logic [7:0] dev_row = '0;
  bit   first_col = 0;
  int   cols_in_row = 0;
  int   cbr_count = 0, ras_opens = 0, page_hits = 0;
  int   last_cbr = -1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid, "R12 reset idle",
          {26'd0, ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid}, 32'h3C);
    end else begin
      // row strobe falls
      if (p_ras && !ras_n) begin
        chk(ras_hi >= T_RP, "R9 precharge", ras_hi, T_RP);
        if (!cas_n) begin
          cbr_count++;
          chk(cas_lo >= T_CSR, "R6 csr lead", cas_lo, T_CSR);
          chk(oe_n && !dq_oe, "R6 quiet bus", {oe_n, dq_oe}, 2'b10);
          if (last_cbr >= 0)
            chk((cyc - last_cbr) >= REF_TICKS - 40 && (cyc - last_cbr) <= REF_TICKS + 40,
                "R5 refresh gap", cyc - last_cbr, REF_TICKS);
          last_cbr = cyc;
        end else begin
          ras_opens++;
          dev_row = dram_addr[7:0];
          chk(dram_addr[8] == 1'b0, "R1 row msb", dram_addr[8], 0);
          first_col = 1;
          cols_in_row = 0;
        end
      end
      if (!p_ras && ras_n) chk(ras_lo >= T_RAS, "R8 ras width", ras_lo, T_RAS);
      // column strobe falls inside a data cycle
      if (p_cas && !cas_n && !ras_n) begin
        logic [16:0] full_a;
        full_a = {dev_row, dram_addr};
        chk(ras_lo >= T_RCD, "R10 rcd", ras_lo, T_RCD);
        chk(cas_hi >= T_CP, "R10 cas precharge", cas_hi, T_CP);
        cols_in_row++;
        chk(cols_in_row <= MAX_BURST, "R11 burst cap", cols_in_row, MAX_BURST);
        if (!first_col) page_hits++;
        first_col = 0;
        if (exp_ops.size() == 0) begin
          chk(0, "R1 unexpected access", full_a, 0);
        end else begin
          op_t o;
          o = exp_ops.pop_front();
          chk(full_a == o.a, "R1 address", full_a, o.a);
          chk(we_n == !o.w, "R2 write enable", we_n, !o.w);
          if (o.w) begin
            chk(we_lo >= 1 && dq_oe, "R3 early write", we_lo, 1);
            chk(dq_out == o.d, "R3 write data", dq_out, o.d);
            dev_mem[int'(full_a)] = dq_out;
          end else begin
            chk(!oe_n, "R2 oe low", oe_n, 0);
            dq_in = dev_mem.exists(int'(full_a)) ? dev_mem[int'(full_a)] : fill(full_a);
          end
        end
      end
      if (!p_cas && cas_n) chk(cas_lo >= T_CAS, "R10 cas width", cas_lo, T_CAS);
      if (dq_oe && !oe_n) chk(0, "R3 contention", 1, 0);
      if (ras_n && !cas_n) chk(!req_ready, "R7 ready during refresh", req_ready, 0);
      // read data
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(0, "R2 spurious rd_valid", rd_data, 0);
        else begin
          logic [15:0] e;
          e = exp_rd.pop_front();
          chk(rd_data == e, "R2 read data", rd_data, e);
        end
      end
    end
    // duration bookkeeping
    if (!ras_n) begin ras_lo++; ras_hi = 0; end else begin ras_hi++; ras_lo = 0; end
    if (!cas_n) begin cas_lo++; cas_hi = 0; end else begin cas_hi++; cas_lo = 0; end
    if (!we_n) we_lo++; else we_lo = 0;
    p_ras = ras_n;
    p_cas = cas_n;
  end

  task automatic issue(input bit w, input logic [16:0] a, input logic [15:0] d);
    op_t o;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    o.w = w; o.a = a; o.d = d;
    exp_ops.push_back(o);
    if (w) ref_mem[int'(a)] = d;
    else   exp_rd.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : fill(a));
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_refresh();
    int c0;
    c0 = cbr_count;
    while (cbr_count == c0) @(negedge clk);
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
    chk(exp_ops.size() == 0 && exp_rd.size() == 0, "R2 all returned",
        exp_ops.size() + exp_rd.size(), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    int h0, o0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 boundaries and row misses
    issue(1, 17'h00000, 16'h1234);
    issue(1, 17'h1FFFF, 16'hBEEF);
    issue(0, 17'h00000, 0);
    issue(0, 17'h1FFFF, 0);
    issue(0, 17'h0A5A5, 0);
    issue(1, 17'h00205, 16'hAAAA);
    issue(0, 17'h00405, 0);
    issue(0, 17'h00205, 0);
    drain();

    // R4 page hits: 8 same-row accesses right after a refresh
    wait_refresh();
    h0 = page_hits; o0 = ras_opens;
    issue(1, {8'h33, 9'd0},   16'h0F0F);
    issue(1, {8'h33, 9'd1},   16'hF0F0);
    issue(1, {8'h33, 9'd511}, 16'h5555);
    issue(1, {8'h33, 9'd256}, 16'h0001);
    issue(0, {8'h33, 9'd511}, 0);
    issue(0, {8'h33, 9'd0},   0);
    issue(0, {8'h33, 9'd256}, 0);
    issue(0, {8'h33, 9'd1},   0);
    drain();
    chk(page_hits - h0 == 7, "R4 page hits", page_hits - h0, 7);
    chk(ras_opens - o0 == 1, "R4 single row open", ras_opens - o0, 1);

    // R11 burst limit: 12 same-row reads
    wait_refresh();
    h0 = page_hits; o0 = ras_opens;
    for (int i = 0; i < 12; i++) issue(0, {8'h77, 9'(i * 3)}, 0);
    drain();
    chk(ras_opens - o0 == 2, "R11 reopen after cap", ras_opens - o0, 2);
    chk(page_hits - h0 == 10, "R11 hits across cap", page_hits - h0, 10);

    // R7 refresh closes an idle open page
    issue(0, 17'h12345, 0);
    drain();
    r0 = cbr_count;
    repeat (2 * REF_TICKS + 50) @(negedge clk);
    chk(cbr_count - r0 >= 2, "R7 refresh with idle page", cbr_count - r0, 2);

    // mixed traffic
    for (int i = 0; i < 24; i++)
      issue((i % 3) != 2, 17'(((i * 37) % 4) << 9 | ((i * 101) % 512)), 16'(i * 16'h0111));
    for (int i = 0; i < 24; i++)
      issue(0, 17'(((i * 37) % 4) << 9 | ((i * 101) % 512)), 0);
    drain();

    // R5 overall refresh count
    chk(cbr_count >= cyc / REF_TICKS - 1, "R5 refresh count", cbr_count, cyc / REF_TICKS - 1);
    finish_run();
  end
endmodule